// File: doc/BRIEF.md
# Two-Bank Interrupt Request Controller

This block gathers a vector of interrupt request lines and presents them to a processor as two independent request outputs. One is the normal request and the other is the fast request. Each output has its own bank of control registers. In each bank, every line can be configured as a level input or as an edge input, and a polarity bit selects which level or which edge counts. Edge events are held in a per-line latch until software acknowledges them by writing a one to that line's bit.

Software reaches the registers through a plain 32-bit register port, made of an address, a write strobe, write data and combinational read data. Address bit 5 selects the bank. Bits 4:2 select the register inside the bank. When a request output rises, the handler reads that bank's status word. It services the lowest set bit, acknowledges it if the line is an edge line, and repeats until the status word reads zero. The block has no vectoring and no hardware priority.

Top module: `twin_bank_intc`

## Requirements
- R1: After a synchronous reset, the enable, trigger-mode and polarity registers of both banks read 0, all edge latches are clear, and both `irq_o` and `fiq_o` are low.
- R2: The register word offsets inside a bank are: raw input 0x00, enable 0x04, acknowledge 0x08, trigger mode 0x0C, polarity 0x10, status 0x14. The normal bank sits at base 0x00 and the fast bank at base 0x20. Enable, trigger mode and polarity read back the last value written to them.
- R3: The status word equals the per-line pending vector ANDed with the enable register, where enable bit = 1 means the line is enabled. A bank's request output is high exactly when its status word is nonzero.
- R4: When trigger mode = 0 (level), polarity 0 makes a line pending while its input is high, and polarity 1 makes it pending while its input is low. The status word and the request output reflect an input change two clock edges after the input changes.
- R5: When trigger mode = 1 (edge), polarity 1 latches a rising edge and polarity 0 latches a falling edge. The opposite edge is ignored. A latched edge appears in status three clock edges after the input change, and it stays pending after the input returns to its idle level.
- R6: Writing the acknowledge register clears the edge latch of each bit written as 1. Bits written as 0 have no effect. A level-mode line stays pending regardless of acknowledge writes.
- R7: If an edge is detected on the same clock edge at which that line is acknowledged, the latch stays set.
- R8: The two banks are independent. Configuration and inputs routed through the fast bank do not change the normal bank's registers, status or request, and the reverse also holds.
- R9: The raw input register returns the input vector as seen after the two-stage synchronizer, which is two clock edges after the pins change.
- R10: Reads at offsets outside the twelve mapped registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt request lines |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
Reads return data in the same cycle as the address. Register writes are visible on the cycle after the strobe edge. A level input shows in status and on the request pins two edges after it changes, and an edge input shows three edges after it changes. The bench confirms each of these latencies by checking the output one cycle early and then again exactly when the result is due. All other observations are taken only after the inputs have settled. The coincident edge-and-acknowledge case is timed so that the write lands on the same edge as the detection.

// File: rtl/tbi_pkg.sv
package tbi_pkg;

    localparam int BANK_BIT = 5;
    localparam int BANKS    = 2;

    typedef enum logic [2:0] {
        REG_RAW  = 3'd0,
        REG_EN   = 3'd1,
        REG_ACK  = 3'd2,
        REG_TRIG = 3'd3,
        REG_POL  = 3'd4,
        REG_STAT = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     bank;
        reg_sel_e sel;
    } reg_dec_t;

    // Byte address to bank and register; anything off-map misses.
    function automatic reg_dec_t decode_addr(input logic [15:0] a);
        reg_dec_t d;
        d.bank = a[BANK_BIT];
        d.sel  = reg_sel_e'(a[4:2]);
        d.hit  = (a[15:BANK_BIT+1] == '0) && (a[1:0] == 2'b00) && (a[4:2] <= 3'd5);
        return d;
    endfunction

endpackage

// File: rtl/tbi_sync.sv
module tbi_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_prev_o
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[STAGES-1];
        end
    end

    assign q_o      = stg[STAGES-1];
    assign q_prev_o = prev_q;
endmodule

// File: rtl/tbi_bank.sv
module tbi_bank
    import tbi_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] lvl_prev_i,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata,
    output logic         req_o
);
    logic [N-1:0] en_q, trig_q, pol_q, latch_q;
    logic [N-1:0] ack, rise, fall, ev, pend, stat;

    assign ack  = (wr_en && sel == REG_ACK) ? wdata : '0;
    assign rise = lvl_i & ~lvl_prev_i;
    assign fall = ~lvl_i & lvl_prev_i;
    assign ev   = (pol_q & rise) | (~pol_q & fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            trig_q  <= '0;
            pol_q   <= '0;
            latch_q <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    REG_EN:   en_q   <= wdata;
                    REG_TRIG: trig_q <= wdata;
                    REG_POL:  pol_q  <= wdata;
                    default: ;
                endcase
            end
            // set wins over acknowledge so a coincident event survives
            latch_q <= ((latch_q & ~ack) | ev) & trig_q;
        end
    end

    assign pend  = (trig_q & latch_q) | (~trig_q & (lvl_i ^ pol_q));
    assign stat  = pend & en_q;
    assign req_o = |stat;

    always_comb begin
        case (sel)
            REG_RAW:  rdata = lvl_i;
            REG_EN:   rdata = en_q;
            REG_TRIG: rdata = trig_q;
            REG_POL:  rdata = pol_q;
            REG_STAT: rdata = stat;
            default:  rdata = '0;
        endcase
    end

    // R6: acknowledged bits without a fresh event are clear afterwards
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (|ack) |=> ((latch_q & $past(ack) & ~$past(ev)) == '0));

    // R5: a qualifying edge in edge mode is held on the next cycle
    p_edge_held_r5: assert property (@(posedge clk) disable iff (rst)
        (|(ev & trig_q)) |=> ((latch_q & $past(ev & trig_q)) == $past(ev & trig_q)));

    // R7: an event coinciding with its acknowledge is kept
    p_event_beats_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (|(ev & trig_q & ack)) |=> ((latch_q & $past(ev & trig_q & ack)) != '0));

    // R3: nothing enabled means no request
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !req_o);

    // R2: enable register takes the written word
    p_enable_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_EN) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/twin_bank_intc.sv
module twin_bank_intc
    import tbi_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int AW      = 6,
    parameter int SYNC_ST = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    logic [NSRC-1:0] lvl, lvl_prev;
    logic [NSRC-1:0] rd [BANKS];
    logic [BANKS-1:0] req;
    reg_dec_t dec;

    assign dec = decode_addr(16'(bus_addr));

    tbi_sync #(.W(NSRC), .STAGES(SYNC_ST)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .d_i      (src_i),
        .q_o      (lvl),
        .q_prev_o (lvl_prev)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        tbi_bank #(.N(NSRC)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .lvl_i      (lvl),
            .lvl_prev_i (lvl_prev),
            .wr_en      (bus_we && dec.hit && (dec.bank == 1'(b))),
            .sel        (dec.sel),
            .wdata      (bus_wdata),
            .rdata      (rd[b]),
            .req_o      (req[b])
        );
    end

    assign bus_rdata = dec.hit ? rd[dec.bank] : '0;
    assign irq_o     = req[0];
    assign fiq_o     = req[1];
endmodule

// File: tb/twin_bank_intc_test.sv
module twin_bank_intc_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    twin_bank_intc uut (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq_o, 2 fiq_o
        logic [31:0] exp;
        string       rq;
    } item_t;

    item_t q[$];
    int applied = 0;
    int fails   = 0;
    bit done    = 0;

    // monitor: compares queued expectations once outputs have settled
    initial forever begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                1:       act = {31'b0, irq_o};
                2:       act = {31'b0, fiq_o};
                default: act = bus_rdata;
            endcase
            applied++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.rq, act, it.exp);
            end
        end
    end

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input string rq);
        @(negedge clk);
        bus_addr = a;
        q.push_back('{0, e, rq});
    endtask

    task automatic chk_pin(input int k, input logic e, input string rq);
        @(negedge clk);
        q.push_back('{k, {31'b0, e}, rq});
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // R1 reset state
        chk_rd(6'h04, 32'h0, "R1 irq enable");
        chk_rd(6'h0C, 32'h0, "R1 irq mode");
        chk_rd(6'h10, 32'h0, "R1 irq polarity");
        chk_rd(6'h24, 32'h0, "R1 fiq enable");
        chk_rd(6'h34, 32'h0, "R1 fiq status");
        chk_pin(1, 1'b0, "R1 irq_o");
        chk_pin(2, 1'b0, "R1 fiq_o");

        // R2 register map and readback
        wr(6'h04, 32'hA5A5_0F0F);
        chk_rd(6'h04, 32'hA5A5_0F0F, "R2 irq enable readback");
        wr(6'h2C, 32'h0000_FFFF);
        chk_rd(6'h2C, 32'h0000_FFFF, "R2 fiq mode readback");
        wr(6'h30, 32'h1234_5678);
        chk_rd(6'h30, 32'h1234_5678, "R2 fiq polarity readback");
        chk_rd(6'h0C, 32'h0, "R2 irq mode untouched");
        wr(6'h04, 0); wr(6'h2C, 0); wr(6'h30, 0);

        // R10 unmapped offsets
        chk_rd(6'h18, 32'h0, "R10 offset 0x18");
        chk_rd(6'h3C, 32'h0, "R10 offset 0x3C");

        // R4 level high, latency two edges
        wr(6'h04, 32'h1);
        set_src(32'h1);
        chk_pin(1, 1'b0, "R4 level not yet visible");
        chk_pin(1, 1'b1, "R4 level visible after two edges");
        chk_rd(6'h14, 32'h1, "R4 status level");
        // R3 and R9: masked line pending but hidden; raw shows both
        set_src(32'h3);
        idle(3);
        chk_rd(6'h14, 32'h1, "R3 masked line hidden");
        chk_rd(6'h00, 32'h3, "R9 raw input");
        // R6 level unaffected by acknowledge
        wr(6'h08, 32'h1);
        chk_rd(6'h14, 32'h1, "R6 level survives ack");
        set_src(32'h0);
        idle(3);
        chk_pin(1, 1'b0, "R4 level released");
        // R4 active-low
        wr(6'h10, 32'h1);
        idle(1);
        chk_rd(6'h14, 32'h1, "R4 active low pending");
        set_src(32'h1);
        idle(3);
        chk_rd(6'h14, 32'h0, "R4 active low idle");
        set_src(32'h0);
        wr(6'h10, 0);

        // R5 rising edge on bit 4, latency three edges
        wr(6'h0C, 32'h30);
        wr(6'h10, 32'h10);
        wr(6'h04, 32'h30);
        idle(3);
        chk_pin(1, 1'b0, "R5 quiet before edge");
        set_src(32'h10);
        chk_pin(1, 1'b0, "R5 edge cycle 1");
        chk_pin(1, 1'b0, "R5 edge cycle 2");
        chk_pin(1, 1'b1, "R5 edge latched at cycle 3");
        set_src(32'h0);
        idle(3);
        chk_rd(6'h14, 32'h10, "R5 latch held after input drops");
        // R6 zero bits ignored, one bits clear
        wr(6'h08, 32'h0000_0020);
        chk_rd(6'h14, 32'h10, "R6 zero bit no effect");
        wr(6'h08, 32'h10);
        chk_rd(6'h14, 32'h0, "R6 ack clears");
        chk_pin(1, 1'b0, "R6 request drops");
        // R5 falling edge on bit 5: rising ignored
        set_src(32'h20);
        idle(4);
        chk_rd(6'h14, 32'h0, "R5 falling line ignores rise");
        set_src(32'h0);
        idle(3);
        chk_rd(6'h14, 32'h20, "R5 falling edge latched");
        wr(6'h08, 32'h20);
        chk_rd(6'h14, 32'h0, "R6 falling latch cleared");

        // R7 edge coincident with acknowledge
        set_src(32'h10);
        idle(4);
        set_src(32'h0);
        idle(4);
        chk_rd(6'h14, 32'h10, "R7 latch preset");
        set_src(32'h10);
        @(negedge clk);
        wr(6'h08, 32'h10);
        chk_rd(6'h14, 32'h10, "R7 coincident edge kept");
        wr(6'h08, 32'h10);
        chk_rd(6'h14, 32'h0, "R7 later ack clears");

        // R8 bank independence
        wr(6'h04, 32'h0);
        wr(6'h24, 32'h100);
        set_src(32'h100);
        idle(3);
        chk_pin(2, 1'b1, "R8 fiq asserted");
        chk_pin(1, 1'b0, "R8 irq stays low");
        chk_rd(6'h34, 32'h100, "R8 fiq status");
        chk_rd(6'h14, 32'h0, "R8 irq status");
        chk_rd(6'h0C, 32'h30, "R8 irq mode unchanged");
        chk_rd(6'h2C, 32'h0, "R8 fiq mode separate");

        @(negedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule